// File: doc/BRIEF.md
# Banked GPIO Edge Interrupt Controller

This block watches a set of already-synchronized GPIO pin inputs for edges and turns them into a small number of interrupt lines. For every pin, software chooses rising-edge detection, falling-edge detection, both or neither. Each choice is changed through a write-one-to-set alias and a write-one-to-clear alias, so a driver never needs a read-modify-write sequence. An edge on an enabled pin sets a sticky status bit. Software clears that bit by writing 1 to it.

Status bits are grouped into banks of 16 pins, and each bank drives one interrupt line. A per-bank enable register gates these lines. A 32-pin register word therefore feeds two banks: the lower half of the word feeds the even bank and the upper half feeds the odd bank. Pin `p` lands in word `p/32`, bit `p%32`, bank `p/16`. The register port is a plain single-cycle write strobe with a combinational read path. The pin count is a parameter, from 1 up to 144.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every rising enable, falling enable, status bit and bank enable reads 0, and every bank interrupt is 0. An asserted reset clears them immediately.
- R2: Word `w` starts at byte address 0x10 + 0x20*w. Within a word, the rising-set alias is at +0x00, rising-clear at +0x04, falling-set at +0x08, falling-clear at +0x0C and status at +0x10. A write to rising-set turns on the rising enable of every pin whose data bit is 1 and leaves the other pins alone. Reading either rising alias returns the rising enable mask.
- R3: A write to rising-clear turns off the rising enable of every pin whose data bit is 1 and leaves the other pins alone.
- R4: The falling-set and falling-clear aliases act on the falling enables in the same way as R2 and R3. Reading either falling alias returns the falling enable mask.
- R5: A 0-to-1 change of a pin between two consecutive clocks sets its status bit on the clock that sees the change, provided the rising enable is on. With only the rising enable on, a 1-to-0 change sets nothing.
- R6: With both enables on, a pin latches status on a 1-to-0 change as well as on a 0-to-1 change.
- R7: An edge on a pin with neither enable on leaves its status bit at 0.
- R8: Status bits stay set after the pin returns to its old level. Writing 1 to a status bit clears it, and status bits written with 0 are unchanged.
- R9: When a new enabled edge and a clear write hit the same status bit in the same clock, the bit ends up set.
- R10: Bank `k` takes status bits [15:0] of word `k/2` when `k` is even and bits [31:16] when `k` is odd. Its interrupt output `bank_irq[k]` is 1 exactly when its bank enable is 1 and at least one of those 16 bits is set.
- R11: The bank enable register sits at byte address 0x08, with bit `k` for bank `k`, and it reads back what was written. Clearing a bank's enable drops that bank's interrupt without changing its status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte address for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bank_irq | output | NUM_PINS/16 rounded up | One interrupt line per 16-pin bank |

## Verification
The pin patterns drive several pins of one word at once, and each pin has a different enable setup: both edges, rising only, or none. One capture therefore shows whether the rising and falling paths are told apart per pin and whether an enable leaks to a neighbour. A separate change on a pin in the upper half of the second word shows whether the half-word-to-bank mapping reaches the odd bank instead of the even one. Partial write-one-to-clear patterns, the clear arriving in the same clock as an edge, and toggling a bank enable while its status is held separate the sticky status from the gated interrupt.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WORD_PINS   = 32;
  localparam int BANK_PINS   = 16;
  localparam int BANK_EN_OFS = 8'h08;
  localparam int WORD_BASE   = 8'h10;
  localparam int WORD_STRIDE = 8'h20;

  typedef enum logic [2:0] {
    SEL_RISE_SET,
    SEL_RISE_CLR,
    SEL_FALL_SET,
    SEL_FALL_CLR,
    SEL_STATUS,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [4:0] ofs);
    case (ofs)
      5'h00:   return SEL_RISE_SET;
      5'h04:   return SEL_RISE_CLR;
      5'h08:   return SEL_FALL_SET;
      5'h0C:   return SEL_FALL_CLR;
      5'h10:   return SEL_STATUS;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_edge_word.sv
module gpio_edge_word
  import gpio_irq_pkg::*;
#(
  parameter int VALID_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pin_in,
  input  logic        wr_en,
  input  reg_sel_e    wsel,
  input  logic [31:0] wdata,
  output logic [31:0] rise_en,
  output logic [31:0] fall_en,
  output logic [31:0] status
);

  localparam logic [31:0] VALID_MASK =
    (VALID_BITS >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << VALID_BITS) - 64'd1);

  logic [31:0] pin_q;
  logic [31:0] rise_en_q, rise_en_d;
  logic [31:0] fall_en_q, fall_en_d;
  logic [31:0] status_q, status_d;
  logic [31:0] clr_mask;
  logic [31:0] edge_v;
  logic        en_upd;
  logic        sts_upd;

  // next-state logic
  always_comb begin
    rise_en_d = rise_en_q;
    fall_en_d = fall_en_q;
    clr_mask  = '0;
    if (wr_en) begin
      case (wsel)
        SEL_RISE_SET: rise_en_d = rise_en_q | wdata;
        SEL_RISE_CLR: rise_en_d = rise_en_q & ~wdata;
        SEL_FALL_SET: fall_en_d = fall_en_q | wdata;
        SEL_FALL_CLR: fall_en_d = fall_en_q & ~wdata;
        SEL_STATUS:   clr_mask  = wdata;
        default:      ;
      endcase
    end
    rise_en_d = rise_en_d & VALID_MASK;
    fall_en_d = fall_en_d & VALID_MASK;
    edge_v    = ((pin_in & ~pin_q & rise_en_q) |
                 (~pin_in & pin_q & fall_en_q)) & VALID_MASK;
    // a fresh edge overrides a clear aimed at the same bit
    status_d  = (status_q & ~clr_mask) | edge_v;
    en_upd    = wr_en && (wsel != SEL_STATUS) && (wsel != SEL_NONE);
    sts_upd   = (wr_en && (wsel == SEL_STATUS)) || (|edge_v);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      status_q  <= '0;
    end else begin
      pin_q <= pin_in;
      if (en_upd) begin
        rise_en_q <= rise_en_d;
        fall_en_q <= fall_en_d;
      end
      if (sts_upd) begin
        status_q <= status_d;
      end
    end
  end

  assign rise_en = rise_en_q;
  assign fall_en = fall_en_q;
  assign status  = status_q;

  // R2
  rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_RISE_SET) |=>
      ((rise_en_q & $past(wdata & VALID_MASK)) == $past(wdata & VALID_MASK)));

  // R3
  rise_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_RISE_CLR) |=> ((rise_en_q & $past(wdata)) == '0));

  // R4
  fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_FALL_CLR) |=> ((fall_en_q & $past(wdata)) == '0));

  // R7
  no_unenabled_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) &
               ~($past(rise_en_q) | $past(fall_en_q))) == '0));

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wsel == SEL_STATUS) |=>
      ((status_q & $past(status_q)) == $past(status_q)));

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_v) |=> ((status_q & $past(edge_v)) == $past(edge_v)));

endmodule

// File: rtl/gpio_bank_gate.sv
module gpio_bank_gate #(
  parameter int NUM_BANKS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_wr,
  input  logic [NUM_BANKS-1:0]    en_wdata,
  input  logic [NUM_BANKS*16-1:0] status_all,
  output logic [NUM_BANKS-1:0]    bank_en,
  output logic [NUM_BANKS-1:0]    irq
);

  logic [NUM_BANKS-1:0] bank_en_q, bank_en_d;

  always_comb begin
    bank_en_d = bank_en_q;
    if (en_wr) bank_en_d = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_en_q <= '0;
    end else if (en_wr) begin
      bank_en_q <= bank_en_d;
    end
  end

  // status bits of bank k are the contiguous slice k*16 .. k*16+15
  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    assign irq[k] = bank_en_q[k] & (|status_all[k*16 +: 16]);
  end

  assign bank_en = bank_en_q;

  // R11
  bank_en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (bank_en_q == $past(en_wdata)));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NUM_PINS-1:0]                     pin_in,
  input  logic                                    bus_we,
  input  logic [ADDR_W-1:0]                       bus_addr,
  input  logic [31:0]                             bus_wdata,
  output logic [31:0]                             bus_rdata,
  output logic [(NUM_PINS+BANK_PINS-1)/BANK_PINS-1:0] bank_irq
);

  localparam int NUM_WORDS = (NUM_PINS + WORD_PINS - 1) / WORD_PINS;
  localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;
  localparam int PAD_W     = NUM_WORDS * WORD_PINS;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [PAD_W-1:0]     pins_pad;
  logic [PAD_W-1:0]     status_all;
  logic [PAD_W-1:0]     rise_all;
  logic [PAD_W-1:0]     fall_all;
  logic [PAD_W-1:0]     word_rd_all;
  logic [NUM_BANKS-1:0] bank_en;
  logic                 bank_en_hit;

  always_comb begin
    pins_pad = '0;
    pins_pad[NUM_PINS-1:0] = pin_in;
  end

  assign bank_en_hit = (bus_addr == ADDR_W'(BANK_EN_OFS));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int BASE  = WORD_BASE + w * WORD_STRIDE;
    localparam int VBITS = (NUM_PINS - w * WORD_PINS >= WORD_PINS) ?
                           WORD_PINS : (NUM_PINS - w * WORD_PINS);

    logic [ADDR_W-1:0] rel;
    logic              in_win;
    reg_sel_e          sel;

    assign rel    = bus_addr - ADDR_W'(BASE);
    assign in_win = (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + WORD_STRIDE);
    assign sel    = in_win ? decode_sel(rel[4:0]) : SEL_NONE;

    gpio_edge_word #(
      .VALID_BITS(VBITS)
    ) u_word (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pin_in  (pins_pad[w*32 +: 32]),
      .wr_en   (bus_we && (sel != SEL_NONE)),
      .wsel    (sel),
      .wdata   (bus_wdata),
      .rise_en (rise_all[w*32 +: 32]),
      .fall_en (fall_all[w*32 +: 32]),
      .status  (status_all[w*32 +: 32])
    );

    always_comb begin
      case (sel)
        SEL_RISE_SET, SEL_RISE_CLR: word_rd_all[w*32 +: 32] = rise_all[w*32 +: 32];
        SEL_FALL_SET, SEL_FALL_CLR: word_rd_all[w*32 +: 32] = fall_all[w*32 +: 32];
        SEL_STATUS:                 word_rd_all[w*32 +: 32] = status_all[w*32 +: 32];
        default:                    word_rd_all[w*32 +: 32] = '0;
      endcase
    end
  end

  gpio_bank_gate #(
    .NUM_BANKS(NUM_BANKS)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en_wr      (bus_we && bank_en_hit),
    .en_wdata   (bus_wdata[NUM_BANKS-1:0]),
    .status_all (status_all[NUM_BANKS*16-1:0]),
    .bank_en    (bank_en),
    .irq        (bank_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bank_en_hit) bus_rdata = 32'(bank_en);
    for (int w = 0; w < NUM_WORDS; w++) begin
      bus_rdata = bus_rdata | word_rd_all[w*32 +: 32];
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (bank_irq == '0));

endmodule

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq;

  localparam int NUM_PINS = 64;
  localparam int NB       = 4;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_PIN = 2'd2;
  localparam logic [1:0] OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t TABLE [NV] = '{
    '{OP_WR,  4'd2,  8'h10, 32'h0000_00F1, 32'h0},          // R2 set rise
    '{OP_RD,  4'd2,  8'h10, 32'h0, 32'h0000_00F1},
    '{OP_RD,  4'd2,  8'h14, 32'h0, 32'h0000_00F1},
    '{OP_WR,  4'd2,  8'h10, 32'h0000_0100, 32'h0},
    '{OP_RD,  4'd2,  8'h10, 32'h0, 32'h0000_01F1},
    '{OP_WR,  4'd3,  8'h14, 32'h0000_00F0, 32'h0},          // R3 clear rise
    '{OP_RD,  4'd3,  8'h10, 32'h0, 32'h0000_0101},
    '{OP_RD,  4'd3,  8'h14, 32'h0, 32'h0000_0101},
    '{OP_WR,  4'd4,  8'h18, 32'h0000_0003, 32'h0},          // R4 falling aliases
    '{OP_WR,  4'd4,  8'h1C, 32'h0000_0002, 32'h0},
    '{OP_RD,  4'd4,  8'h18, 32'h0, 32'h0000_0001},
    '{OP_RD,  4'd4,  8'h1C, 32'h0, 32'h0000_0001},
    '{OP_WR,  4'd11, 8'h08, 32'h0000_000F, 32'h0},          // R11 bank enables
    '{OP_RD,  4'd11, 8'h08, 32'h0, 32'h0000_000F},
    '{OP_PIN, 4'd5,  8'h00, 32'h0000_0103, 32'h0},          // R5 rise pins 0,1,8
    '{OP_RD,  4'd5,  8'h20, 32'h0, 32'h0000_0101},          // R7 pin 1 stays 0
    '{OP_IRQ, 4'd10, 8'h00, 32'h0, 32'h0000_0001},
    '{OP_WR,  4'd8,  8'h20, 32'h0000_0100, 32'h0},          // R8 partial clear
    '{OP_RD,  4'd8,  8'h20, 32'h0, 32'h0000_0001},
    '{OP_WR,  4'd8,  8'h20, 32'h0000_0001, 32'h0},
    '{OP_RD,  4'd8,  8'h20, 32'h0, 32'h0},
    '{OP_IRQ, 4'd10, 8'h00, 32'h0, 32'h0},
    '{OP_PIN, 4'd6,  8'h00, 32'h0, 32'h0},                  // R6 falls on 0,1,8
    '{OP_RD,  4'd6,  8'h20, 32'h0, 32'h0000_0001},
    '{OP_WR,  4'd8,  8'h20, 32'h0000_0001, 32'h0},
    '{OP_RD,  4'd7,  8'h20, 32'h0, 32'h0},
    '{OP_WR,  4'd10, 8'h30, 32'h0001_0000, 32'h0},          // R10 pin 48, bank 3
    '{OP_PIN, 4'd10, 8'h01, 32'h0001_0000, 32'h0},
    '{OP_RD,  4'd10, 8'h40, 32'h0, 32'h0001_0000},
    '{OP_IRQ, 4'd10, 8'h00, 32'h0, 32'h0000_0008},
    '{OP_WR,  4'd11, 8'h08, 32'h0000_0007, 32'h0},
    '{OP_IRQ, 4'd11, 8'h00, 32'h0, 32'h0},
    '{OP_RD,  4'd11, 8'h40, 32'h0, 32'h0001_0000},
    '{OP_WR,  4'd11, 8'h08, 32'h0000_000F, 32'h0},
    '{OP_IRQ, 4'd11, 8'h00, 32'h0, 32'h0000_0008},
    '{OP_WR,  4'd8,  8'h40, 32'h0001_0000, 32'h0},
    '{OP_IRQ, 4'd10, 8'h00, 32'h0, 32'h0},
    '{OP_RD,  4'd8,  8'h40, 32'h0, 32'h0}
  };

  logic                clk = 1'b0;
  logic                rst_n;
  logic [NUM_PINS-1:0] pin_in;
  logic                bus_we;
  logic [7:0]          bus_addr;
  logic [31:0]         bus_wdata;
  logic [31:0]         bus_rdata;
  logic [NB-1:0]       bank_irq;

  int compared   = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  gpio_edge_irq #(.NUM_PINS(NUM_PINS), .ADDR_W(8)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bank_irq  (bank_irq)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd_chk(input int req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp, $sformatf("read 0x%02h", a));
  endtask

  task automatic run_vec(input vec_t v);
    case (v.op)
      OP_WR:  begin bus_we = 1'b1; bus_addr = v.addr; bus_wdata = v.data; end
      OP_PIN: pin_in[v.addr[0]*32 +: 32] = v.data;
      OP_RD:  rd_chk(int'(v.req), v.addr, v.exp);
      default: begin #1; chk(int'(v.req), 32'(bank_irq), v.exp, "irq"); end
    endcase
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_chk(1, 8'h10, 32'h0);
    rd_chk(1, 8'h18, 32'h0);
    rd_chk(1, 8'h20, 32'h0);
    rd_chk(1, 8'h08, 32'h0);
    chk(1, 32'(bank_irq), 32'h0, "irq after reset");

    for (int i = 0; i < NV; i++) run_vec(TABLE[i]);

    // R9 edge on pin 0 and clear of bit 0 in the same clock
    pin_in[0] = 1'b1;
    bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    rd_chk(9, 8'h20, 32'h1);
    chk(9, 32'(bank_irq), 32'h1, "irq after edge beat clear");

    // R8 clear with pin steady
    bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    rd_chk(8, 8'h20, 32'h0);

    // R1 reset in the middle of operation
    rst_n = 1'b0;
    rd_chk(1, 8'h10, 32'h0);
    rd_chk(1, 8'h30, 32'h0);
    rd_chk(1, 8'h18, 32'h0);
    rd_chk(1, 8'h08, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk(1, 8'h20, 32'h0);
    chk(1, 32'(bank_irq), 32'h0, "irq after second reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule